// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a large set of level-sensitive interrupt sources into groups of eight and raises one output line per group toward a parent interrupt controller. Each source has its own enable bit. A source counts as pending when its input is high and its enable bit is set. A group's output stays high for as long as at least one of its sources is pending.

Software reaches the block through a simple register port. Writes use address, write data and a write strobe. Reads use a read strobe, and the read data comes back on the next cycle. Every 32-bit register bank covers four consecutive groups. Each bank has three registers:

- a write-one-to-set enable register,
- a write-one-to-clear enable register,
- a read-only pending-status register.

Because set and clear are separate registers, software never needs a read-modify-write to change enables. Next to each group's output line, the block also gives the index of the lowest-numbered pending source in that group and a valid flag. A handler can use these without reading the bus.

Top module: `irq_combiner`

## Requirements
- R1: After reset, every enable bit is 0, and every group output and valid flag is 0.
- R2: A write to word offset 0x0 of a bank sets each enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bit unchanged.
- R3: A write to word offset 0x4 of a bank clears each enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bit unchanged.
- R4: Offset 0xC of a bank reads as the source levels ANDed with their enable bits. Writes to offset 0xC change nothing.
- R5: Bank b sits at address b*0x10 and covers groups 4b to 4b+3. Group g uses bits [8*(g mod 4)+7 : 8*(g mod 4)] of its bank. Source n is bit n mod 8 of group n/8.
- R6: Each group output is a register. It goes high one clock after any enabled source in that group is high. It stays high while any enabled source remains high, and it goes low one clock after the last one drops.
- R7: Each group has a 3-bit index field that gives the lowest-numbered pending source of the group, so bit 0 has the highest priority. It also has a valid flag. Both are updated on the same edge as the group output.
- R8: Reads of offsets 0x0 and 0x4 return the current enable bits. Read data appears on the clock after the read strobe and holds its value until the next read.
- R9: Offset 0x8, and any bank at or beyond ceil(NUM_GROUPS/4), read as zero. Writes to them change no state.
- R10: The default configuration has 20 groups, which is 160 sources and 5 banks. The group count is set by a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources; source n at bit n |
| addr | input | ADDR_W | Byte address; bits [3:2] select the word and the upper bits select the bank |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| grp_irq | output | NUM_GROUPS | One interrupt output per group |
| grp_idx | output | NUM_GROUPS*3 | Lowest pending source index; group g at bits [3g+2:3g] |
| grp_vld | output | NUM_GROUPS | Group g has a pending source, so its index field is meaningful |

## Verification
An enable write takes effect on the write's clock edge. A status read then reflects it in the read data one clock after the read strobe. A change on a source or on an enable reaches the group output, index and valid flag one clock later. The bench drives every stimulus on the falling edge, lets one rising edge pass and samples on the next falling edge, so each check sees exactly that one register stage. The level behaviour is checked by lowering the sources one at a time and sampling after each change.

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*8-1:0] src_i,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic                    wr_en,
  input  logic                    rd_en,
  output logic [31:0]             rdata,
  output logic [NUM_GROUPS-1:0]   grp_irq,
  output logic [NUM_GROUPS*3-1:0] grp_idx,
  output logic [NUM_GROUPS-1:0]   grp_vld
);
  localparam int NSRC  = NUM_GROUPS * 8;
  localparam int NBANK = (NUM_GROUPS + 3) / 4;
  localparam int PW    = NBANK * 32;
  localparam logic [PW-1:0] VMASK = PW'({NSRC{1'b1}});

  logic [PW-1:0] en_q, en_d, stat;
  logic [ADDR_W-5:0] bank;
  logic [1:0] word;
  logic bank_ok;
  int bidx;

  assign stat    = PW'(src_i) & en_q;
  assign bank    = addr[ADDR_W-1:4];
  assign word    = addr[3:2];
  assign bank_ok = int'(bank) < NBANK;
  assign bidx    = bank_ok ? int'(bank) : 0;

  always_comb begin
    en_d = en_q;
    if (wr_en && bank_ok) begin
      if (word == 2'd0) en_d[bidx*32 +: 32] = en_q[bidx*32 +: 32] | wdata;
      else if (word == 2'd1) en_d[bidx*32 +: 32] = en_q[bidx*32 +: 32] & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d & VMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      if (!bank_ok)                      rdata <= '0;
      else if (word == 2'd0 || word == 2'd1) rdata <= en_q[bidx*32 +: 32];
      else if (word == 2'd3)             rdata <= stat[bidx*32 +: 32];
      else                               rdata <= '0;
    end
  end

  function automatic logic [2:0] lowest(input logic [7:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp_irq[g]       <= 1'b0;
        grp_vld[g]       <= 1'b0;
        grp_idx[3*g +: 3] <= 3'd0;
      end else begin
        grp_irq[g]       <= |stat[8*g +: 8];
        grp_vld[g]       <= |stat[8*g +: 8];
        grp_idx[3*g +: 3] <= lowest(stat[8*g +: 8]);
      end
    end
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_GROUPS*8-1:0] src_i,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wdata,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [31:0]             rdata,
  input logic [NUM_GROUPS-1:0]   grp_irq,
  input logic [NUM_GROUPS*3-1:0] grp_idx,
  input logic [NUM_GROUPS-1:0]   grp_vld,
  input logic [((NUM_GROUPS+3)/4)*32-1:0] en_q
);
  AST_SET_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> ((en_q[31:0] & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=> ((en_q[31:0] & $past(wdata)) == 32'd0)); // R3
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] == $past(|(src_i[8*g +: 8] & en_q[8*g +: 8]))); // R6
    AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      grp_vld[g] |-> (((($past(src_i[8*g +: 8] & en_q[8*g +: 8])) >> grp_idx[3*g +: 3]) & 8'd1) == 8'd1)); // R7
  end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
  localparam int NG = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NG*8-1:0] src_i = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic [NG-1:0] grp_irq, grp_vld;
  logic [NG*3-1:0] grp_idx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_combiner u_irq_combiner (.clk(clk), .rst_n(rst_n), .src_i(src_i), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .grp_irq(grp_irq), .grp_idx(grp_idx), .grp_vld(grp_vld));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(grp_irq), 0);
    chk("R1 vld", 32'(grp_vld), 0);
    rd(8'h00, d); chk("R1 enables bank0", d, 0);
    rd(8'h40, d); chk("R1 enables bank4", d, 0);
    chk("R10 group count", 32'($bits(grp_irq)), 20);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(8'h00, 32'h0000_00A5); rd(8'h00, d); chk("R2 set", d, 32'h0000_00A5);
    wr(8'h00, 32'h0000_0100); rd(8'h00, d); chk("R2 zeros no effect", d, 32'h0000_01A5);
    wr(8'h04, 32'h0000_0005); rd(8'h00, d); chk("R3 clear", d, 32'h0000_01A0);
    rd(8'h04, d); chk("R8 read via clear offset", d, 32'h0000_01A0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk); src_i[7:0] = 8'hFF;
    rd(8'h0C, d); chk("R4 status", d, 32'h0000_00A0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h00, d); chk("R4 status write ignored", d, 32'h0000_01A0);
  endtask

  task automatic t_irq_level;
    chk("R6 grp0 high", 32'(grp_irq[0]), 1);
    chk("R6 grp1 low", 32'(grp_irq[1]), 0);
    chk("R7 idx", 32'(grp_idx[2:0]), 5);
    chk("R7 vld", 32'(grp_vld[0]), 1);
    @(negedge clk); src_i[5] = 1'b0; step();
    chk("R6 level held", 32'(grp_irq[0]), 1);
    chk("R7 next idx", 32'(grp_idx[2:0]), 7);
    @(negedge clk); src_i[7:0] = 8'h00;
    chk("R6 one cycle lag", 32'(grp_irq[0]), 1);
    step();
    chk("R6 drop", 32'(grp_irq[0]), 0);
    chk("R7 vld drop", 32'(grp_vld[0]), 0);
  endtask

  task automatic t_bank;
    logic [31:0] d;
    wr(8'h40, 32'hFF00_0000); rd(8'h40, d); chk("R5 bank4 enables", d, 32'hFF00_0000);
    @(negedge clk); src_i[155] = 1'b1; src_i[158] = 1'b1; step();
    chk("R5 grp19 irq", 32'(grp_irq), 32'h0008_0000);
    chk("R7 grp19 idx", 32'(grp_idx[57 +: 3]), 3);
    rd(8'h4C, d); chk("R5 bank4 status", d, 32'h4800_0000);
  endtask

  task automatic t_unused;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R9 offset 8 reads zero", d, 0);
    rd(8'h50, d); chk("R9 bank5 reads zero", d, 0);
    rd(8'h10, d); chk("R9 bank1 untouched", d, 0);
    rd(8'h00, d); chk("R9 bank0 untouched", d, 32'h0000_01A0);
    repeat (3) step();
    chk("R8 rdata holds", rdata, 32'h0000_01A0);
    chk("R9 irq unchanged", 32'(grp_irq), 32'h0008_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_set_clear();
    t_status();
    t_irq_level();
    t_bank();
    t_unused();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule